// File: doc/BRIEF.md
# Iterative Integer Divider with Zero-Divisor Trap

This block divides one 32-bit operand by another over many clock cycles. It produces the quotient as either a signed result or an unsigned result. A one-cycle `start` pulse launches an operation. `busy` stays high while the shift-subtract loop runs. A one-cycle `done` pulse marks the moment when the quotient and the status outputs are valid. No remainder is produced.

A zero divisor skips the loop entirely: the block completes on the next cycle with a zero quotient and sets the divide-by-zero status bit. It can also request a trap. The trap request depends on two inputs that are sampled with `start`: an exception-enable input, which comes from the machine status register, and a configuration input, which masks divide-by-zero traps. When the trap is requested, the cause output is loaded with the divide-by-zero code. The CPU's exception vectoring sits outside this block and consumes that request and cause.

Top module: `iter_div`

## Requirements
- R1: With `signed_sel`=0, a non-zero divisor gives `quotient` = floor(op_a / op_b), both operands taken as unsigned.
- R2: With `signed_sel`=1, both operands are two's complement and the quotient is truncated toward zero (for example, -7/2 = -3).
- R3: In signed mode, 0x80000000 divided by 0xFFFFFFFF returns 0x80000000 with `dz_flag`=0 and `exc_req`=0.
- R4: For a non-zero divisor, `busy` is high from the clock edge that accepts `start` until `done` rises, and `done` is high for exactly one cycle, 33 clock edges after the accepting edge.
- R5: For a zero divisor, `done` is high for one cycle right after the accepting edge, `quotient` is 0, and `busy` never rises.
- R6: `dz_flag` is set by a zero-divisor completion, cleared by a non-zero-divisor completion, and holds its value between completions.
- R7: `exc_req` is a one-cycle pulse coincident with `done`. It is high only for a zero divisor with `exc_en`=1 and `dz_exc_mask`=0, both sampled with `start`.
- R8: `exc_cause` is loaded with 5'b00101 whenever `exc_req` pulses and otherwise holds its previous value.
- R9: `start` has no effect while `busy` is high. The running operation's quotient and status are unaffected, and no extra `done` occurs.
- R10: After reset, `busy`, `done`, `quotient`, `dz_flag`, `exc_req` and `exc_cause` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, accepted only when not busy |
| op_a | input | 32 | Dividend |
| op_b | input | 32 | Divisor |
| signed_sel | input | 1 | 1 selects two's-complement division |
| exc_en | input | 1 | Global exception enable from the machine status register |
| dz_exc_mask | input | 1 | 1 suppresses the divide-by-zero trap |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Result, updated at completion |
| dz_flag | output | 1 | Divide-by-zero status bit |
| exc_req | output | 1 | Trap request pulse |
| exc_cause | output | 5 | Trap cause code |

## Verification
The hardest situation to produce from the ports is a second `start` arriving in the middle of a running division. The ignored request must leave no trace: the quotient, the status bit and the completion count must all be unchanged. The stimulus deliberately fires `start` partway through some loops. That intruding start carries a zero divisor and trap enables, so any leak would show up as a zero quotient, a raised status bit or a trap request. The overflow case and all four enable/mask combinations under a zero divisor are also forced directly, and random traffic is mixed with them so that `dz_flag` and `exc_cause` are tested for holding across long histories.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int DW      = 32;
  localparam int CW      = $clog2(DW);
  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] DZ_CAUSE = 5'b00101;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} div_state_e;

  // absolute value of an operand when signed mode is selected
  function automatic logic [DW-1:0] magnitude(input logic [DW-1:0] v, input logic sgn);
    return (sgn && v[DW-1]) ? (~v + 1'b1) : v;
  endfunction

  // negate when the operand signs differed
  function automatic logic [DW-1:0] apply_sign(input logic [DW-1:0] v, input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic divisor_zero,
  output logic accept_zero,
  output logic accept_run,
  output logic step,
  output logic finish,
  output logic busy,
  output logic done
);
  div_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic accept;

  assign accept      = start && (state_q == ST_IDLE);
  assign accept_zero = accept && divisor_zero;
  assign accept_run  = accept && !divisor_zero;
  assign step        = (state_q == ST_RUN);
  assign finish      = (state_q == ST_FIN);
  assign busy        = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= accept_zero || finish;
      unique case (state_q)
        ST_IDLE: if (accept_run) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(DW - 1)) state_q <= ST_FIN;
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import div_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          finish,
  input  logic          clear,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  input  logic          sgn,
  output logic [DW-1:0] result
);
  logic [DW-1:0] quo_q, rem_q, dvs_q;
  logic          neg_q;
  logic [DW:0]   shifted, diff;

  assign shifted = {rem_q, quo_q[DW-1]};
  assign diff    = shifted - {1'b0, dvs_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      neg_q  <= 1'b0;
      result <= '0;
    end else begin
      if (load) begin
        quo_q <= magnitude(dividend, sgn);
        dvs_q <= magnitude(divisor, sgn);
        rem_q <= '0;
        neg_q <= sgn && (dividend[DW-1] ^ divisor[DW-1]);
      end else if (step) begin
        if (!diff[DW]) begin
          rem_q <= diff[DW-1:0];
          quo_q <= {quo_q[DW-2:0], 1'b1};
        end else begin
          rem_q <= shifted[DW-1:0];
          quo_q <= {quo_q[DW-2:0], 1'b0};
        end
      end
      if (clear)       result <= '0;
      else if (finish) result <= apply_sign(quo_q, neg_q);
    end
  end
endmodule

// File: rtl/div_trap.sv
module div_trap
  import div_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               zero_event,
  input  logic               good_event,
  input  logic               exc_en,
  input  logic               dz_exc_mask,
  output logic               dz_flag,
  output logic               exc_req,
  output logic [CAUSE_W-1:0] exc_cause
);
  logic raise;
  assign raise = zero_event && exc_en && !dz_exc_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dz_flag   <= 1'b0;
      exc_req   <= 1'b0;
      exc_cause <= '0;
    end else begin
      exc_req <= raise;
      if (zero_event)      dz_flag <= 1'b1;
      else if (good_event) dz_flag <= 1'b0;
      if (raise) exc_cause <= DZ_CAUSE;
    end
  end
endmodule

// File: rtl/iter_div.sv
module iter_div
  import div_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   op_a,
  input  logic [31:0]   op_b,
  input  logic          signed_sel,
  input  logic          exc_en,
  input  logic          dz_exc_mask,
  output logic          busy,
  output logic          done,
  output logic [31:0]   quotient,
  output logic          dz_flag,
  output logic          exc_req,
  output logic [4:0]    exc_cause
);
  // internal events, named for the checker
  logic evt_zero, evt_load, evt_step, evt_finish;

  div_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .divisor_zero(op_b == '0),
    .accept_zero(evt_zero), .accept_run(evt_load), .step(evt_step),
    .finish(evt_finish), .busy(busy), .done(done)
  );

  div_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .load(evt_load), .step(evt_step),
    .finish(evt_finish), .clear(evt_zero), .dividend(op_a), .divisor(op_b),
    .sgn(signed_sel), .result(quotient)
  );

  div_trap u_trap (
    .clk(clk), .rst_n(rst_n), .zero_event(evt_zero), .good_event(evt_finish),
    .exc_en(exc_en), .dz_exc_mask(dz_exc_mask), .dz_flag(dz_flag),
    .exc_req(exc_req), .exc_cause(exc_cause)
  );
endmodule

// File: rtl/iter_div_chk.sv
module iter_div_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [31:0] quotient,
  input logic        dz_flag,
  input logic        exc_req,
  input logic [4:0]  exc_cause,
  input logic        evt_zero,
  input logic        evt_finish
);
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R5
  zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_zero |=> (done && dz_flag && quotient == 32'd0 && !busy));
  // R6
  dz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(dz_flag));
  // R7
  exc_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) exc_req |-> (done && dz_flag));
  // R8
  cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n) exc_req |-> exc_cause == 5'b00101);
  // R8
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !exc_req |-> $stable(exc_cause));
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !(done && dz_flag));
  // R4
  finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n) evt_finish |=> (done && !busy));
  // R1
  result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(quotient));
endmodule

bind iter_div iter_div_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .quotient(quotient), .dz_flag(dz_flag), .exc_req(exc_req), .exc_cause(exc_cause),
  .evt_zero(evt_zero), .evt_finish(evt_finish)
);

// File: tb/iter_div_tb_top.sv
module iter_div_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LAT    = 33;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, signed_sel = 1'b0, exc_en = 1'b0, dz_exc_mask = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic busy, done, dz_flag, exc_req;
  logic [31:0] quotient;
  logic [4:0] exc_cause;

  int n_checks = 0, n_fail = 0;
  logic [4:0] exp_cause = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iter_div dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .signed_sel(signed_sel), .exc_en(exc_en), .dz_exc_mask(dz_exc_mask),
    .busy(busy), .done(done), .quotient(quotient), .dz_flag(dz_flag),
    .exc_req(exc_req), .exc_cause(exc_cause)
  );

  function automatic logic [31:0] ref_quot(input logic [31:0] a, input logic [31:0] b, input logic s);
    longint sa, sb, q;
    if (b == 0) return 32'd0;
    if (!s) return a / b;
    sa = longint'(signed'(a));
    sb = longint'(signed'(b));
    q  = sa / sb;
    return q[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation; poke injects a rogue start mid-loop
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic s,
                        input logic en, input logic msk, input logic poke);
    int cnt;
    logic saw_idle;
    logic exp_exc;
    @(negedge clk);
    op_a = a; op_b = b; signed_sel = s; exc_en = en; dz_exc_mask = msk; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    op_a = $urandom; op_b = $urandom; signed_sel = $urandom; exc_en = $urandom; dz_exc_mask = $urandom;
    cnt = 0; saw_idle = 1'b0;
    while (!done && cnt < 100) begin
      if (!busy) saw_idle = 1'b1;
      if (poke && cnt == 5) begin
        op_b = 32'd0; exc_en = 1'b1; dz_exc_mask = 1'b0; start = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cnt++;
    end
    exp_exc = (b == 0) && en && !msk;
    if (exp_exc) exp_cause = 5'b00101;
    if (b == 0) check("R5 latency", cnt, 0);
    else begin
      check("R4 latency", cnt, RUN_LAT);
      check("R4 busy during loop", {31'd0, saw_idle}, 0);
    end
    check(s ? "R2 quotient" : "R1 quotient", quotient, ref_quot(a, b, s));
    check("R6 dz_flag", {31'd0, dz_flag}, {31'd0, b == 0});
    check("R7 exc_req", {31'd0, exc_req}, {31'd0, exp_exc});
    check("R8 exc_cause", {27'd0, exc_cause}, {27'd0, exp_cause});
    if (poke) check("R9 rogue start ignored", quotient, ref_quot(a, b, s));
    @(negedge clk);
    check("R4 done one cycle", {31'd0, done}, 0);
    check("R5/R9 busy idle after", {31'd0, busy}, 0);
    check("R6 dz hold", {31'd0, dz_flag}, {31'd0, b == 0});
  endtask

  initial begin
    void'($urandom(32'h1234abcd));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 busy", {31'd0, busy}, 0);
    check("R10 done", {31'd0, done}, 0);
    check("R10 quotient", quotient, 0);
    check("R10 dz_flag", {31'd0, dz_flag}, 0);
    check("R10 exc_req", {31'd0, exc_req}, 0);
    check("R10 exc_cause", {27'd0, exc_cause}, 0);
    rst_n = 1'b1;

    run_op(32'd100, 32'd7, 1'b0, 1'b0, 1'b0, 1'b0);               // R1
    run_op(32'hFFFFFFFF, 32'd1, 1'b0, 1'b0, 1'b0, 1'b0);          // R1
    run_op(32'hFFFFFFF9, 32'd2, 1'b1, 1'b0, 1'b0, 1'b0);          // R2 -7/2
    run_op(32'd7, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b0, 1'b0);          // R2 7/-2
    run_op(32'h80000000, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0);   // R3
    check("R3 overflow result", quotient, 32'h80000000);
    run_op(32'd5, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0);                 // R5/R7 no enable
    run_op(32'd5, 32'd0, 1'b1, 1'b1, 1'b1, 1'b0);                 // R7 masked
    run_op(32'd5, 32'd0, 1'b0, 1'b0, 1'b1, 1'b0);                 // R7 both off
    check("R8 cause still zero", {27'd0, exc_cause}, 0);
    run_op(32'd5, 32'd0, 1'b1, 1'b1, 1'b0, 1'b0);                 // R7/R8 trap
    run_op(32'd9, 32'd3, 1'b0, 1'b1, 1'b0, 1'b0);                 // R6 clear, R8 hold
    run_op(32'd1000, 32'd10, 1'b0, 1'b0, 1'b0, 1'b1);             // R9
    run_op(32'h80000000, 32'd3, 1'b1, 1'b1, 1'b0, 1'b1);          // R9 signed

    for (int i = 0; i < 300; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      case ($urandom % 8)
        0: rb = 32'd0;
        1: rb = $urandom % 16;
        2: rb = rb >> ($urandom % 32);
        default: ;
      endcase
      run_op(ra, rb, 1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 10) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule